// File: doc/BRIEF.md
# Machine Cycle Phase Generator

This block divides the oscillator clock into the timing frame of a small 8-bit controller core. Each oscillator period is one phase, either P1 or P2. Two phases make a state, and a fixed number of states (six by default) make one machine cycle of twelve oscillator clocks. All outputs are registered and change on the same clock edge:

- the current state number and phase bit;
- a one-hot state vector for downstream bus decode;
- a strobe that marks the last phase of each machine cycle;
- the address-latch-enable strobe (ALE).

ALE pulses twice per machine cycle, so its rate is one sixth of the oscillator. The first pulse covers the second phase of state 1 and the first phase of state 2. The second pulse covers the second phase of state 4 and the first phase of state 5. A bus controller can suppress either pulse on its own through a separate block input, for example during an external data access. Each block input is sampled once, at the edge that would start its pulse, so a pulse is always either whole or absent.

Top module: `mcph_gen`

## Requirements
- R1: `phase` is 0 (P1) and 1 (P2) on alternate clocks. `state_num` holds its value across P1 to P2 and advances by one on the clock after each P2.
- R2: `state_num` runs 1 to 6 and returns to 1 with phase P1 after S6P2, so the sequence repeats every 12 clocks.
- R3: When not blocked, `ale` is high in exactly two consecutive clocks for the first pulse: S1P2 and S2P1.
- R4: When not blocked, `ale` is also high in S4P2 and S5P1. It is low in every other phase, which gives two pulses per 12 clocks.
- R5: `ale_block_first` is sampled at the clock edge that enters S1P2. If it is 1 there, `ale` stays low through S1P2 and S2P1. A change of the input after that edge has no effect on the pulse already decided.
- R6: `ale_block_second` works the same way for the second pulse. It is sampled at the edge that enters S4P2 and controls S4P2 and S5P1.
- R7: `cycle_end` is high only in S6P2, for one clock per machine cycle.
- R8: `state_onehot` bit k-1 is high exactly when `state_num` equals k. All other bits are low.
- R9: Reset is synchronous. When `rst_n` is low at a rising clock edge, the outputs become S1P1 with `ale` and `cycle_end` low. A change of `rst_n` between edges does not alter any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period is one phase |
| rst_n | input | 1 | Synchronous active-low reset |
| ale_block_first | input | 1 | Suppresses the S1P2/S2P1 ALE pulse when 1 at its start edge |
| ale_block_second | input | 1 | Suppresses the S4P2/S5P1 ALE pulse when 1 at its start edge |
| state_num | output | 3 | Current state, 1 to 6 |
| phase | output | 1 | Current phase: 0 for P1, 1 for P2 |
| state_onehot | output | 6 | One-hot copy of the state number |
| cycle_end | output | 1 | High in the final phase (S6P2) of each machine cycle |
| ale | output | 1 | Address latch enable strobe |

## Verification
The bench builds the block with its default parameters: six states, with the ALE pulses starting in states 1 and 4. With these values a full machine cycle takes only 12 clocks, so the bench can compare every phase over several wraps against its own index-based model. The short cycle also lets the bench place block inputs at, before and inside each pulse window. It changes a block input in the middle of a pulse to check that a pulse is never cut short. It drops reset between clock edges and in the middle of a cycle to check that reset acts only at an edge.

// File: rtl/mcph_pkg.sv
// Package: shared types for the machine cycle phase generator.
// Assumes: phase is one bit, P1 encoded as 0 and P2 as 1.
package mcph_pkg;
    typedef enum logic {
        PH_P1 = 1'b0,
        PH_P2 = 1'b1
    } phase_e;
endpackage

// File: rtl/mcph_phase_ctr.sv
// Module: mcph_phase_ctr
// Holds the current state/phase pair and computes the pair for the next clock.
// A phase pair advances P1 -> P2 and then moves to the next state, wrapping after
// the final state. The next-value outputs already include the reset, so registers
// downstream that load them stay aligned with the counter.
// Assumes: STATES >= 2; rst_n is synchronous to clk.
module mcph_phase_ctr
    import mcph_pkg::*;
#(
    parameter int STATES  = 6,
    parameter int STATE_W = $clog2(STATES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [STATE_W-1:0] cur_state,
    output phase_e             cur_phase,
    output logic [STATE_W-1:0] nxt_state,
    output phase_e             nxt_phase
);
    localparam logic [STATE_W-1:0] FIRST_ST = STATE_W'(1);
    localparam logic [STATE_W-1:0] LAST_ST  = STATE_W'(STATES);

    // Next state/phase: toggle phase, step state after P2, force S1P1 in reset.
    always_comb begin
        if (!rst_n) begin
            nxt_state = FIRST_ST;
            nxt_phase = PH_P1;
        end else if (cur_phase == PH_P2) begin
            nxt_phase = PH_P1;
            nxt_state = (cur_state == LAST_ST) ? FIRST_ST : cur_state + FIRST_ST;
        end else begin
            nxt_phase = PH_P2;
            nxt_state = cur_state;
        end
    end

    // Counter registers: load the computed next pair on each clock.
    always_ff @(posedge clk) begin
        cur_state <= nxt_state;
        cur_phase <= nxt_phase;
    end
endmodule

// File: rtl/mcph_strobe_dec.sv
// Module: mcph_strobe_dec
// Turns the next state/phase pair into registered strobes: the one-hot state,
// the end-of-cycle marker and the two two-phase ALE pulses. Each ALE pulse
// samples its block input only at the edge that enters its first phase and then
// holds for the second phase, so a pulse is never cut short.
// Assumes: each ALE pulse starts in state k (P2) and ends in state k+1 (P1),
// with k+1 <= STATES.
module mcph_strobe_dec
    import mcph_pkg::*;
#(
    parameter int STATES    = 6,
    parameter int ALE_FIRST = 1,
    parameter int ALE_SECOND = 4,
    parameter int STATE_W   = $clog2(STATES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] nxt_state,
    input  phase_e             nxt_phase,
    input  logic               block_first,
    input  logic               block_second,
    output logic [STATES-1:0]  onehot_q,
    output logic               cycle_end_q,
    output logic               ale_q
);
    localparam logic [STATE_W-1:0] A1_ST  = STATE_W'(ALE_FIRST);
    localparam logic [STATE_W-1:0] A1_END = STATE_W'(ALE_FIRST + 1);
    localparam logic [STATE_W-1:0] A2_ST  = STATE_W'(ALE_SECOND);
    localparam logic [STATE_W-1:0] A2_END = STATE_W'(ALE_SECOND + 1);
    localparam logic [STATE_W-1:0] LAST_ST = STATE_W'(STATES);

    // One-hot state register: one flop per state.
    for (genvar k = 0; k < STATES; k++) begin : g_onehot
        always_ff @(posedge clk) begin
            onehot_q[k] <= (nxt_state == STATE_W'(k + 1));
        end
    end

    // End-of-cycle marker: high in the last phase of the last state.
    always_ff @(posedge clk) begin
        cycle_end_q <= rst_n && (nxt_state == LAST_ST) && (nxt_phase == PH_P2);
    end

    // ALE: decide each pulse at its start edge, hold for its second phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
        end else if (nxt_state == A1_ST && nxt_phase == PH_P2) begin
            ale_q <= !block_first;
        end else if (nxt_state == A1_END && nxt_phase == PH_P1) begin
            ale_q <= ale_q;
        end else if (nxt_state == A2_ST && nxt_phase == PH_P2) begin
            ale_q <= !block_second;
        end else if (nxt_state == A2_END && nxt_phase == PH_P1) begin
            ale_q <= ale_q;
        end else begin
            ale_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mcph_gen.sv
// Module: mcph_gen (top)
// Machine cycle phase generator: the phase counter feeds the strobe decoder.
// All outputs are registered and change on the same edge.
// Assumes: one clk period is one phase; rst_n is synchronous, active low.
module mcph_gen
    import mcph_pkg::*;
#(
    parameter int STATES     = 6,
    parameter int ALE_FIRST  = 1,
    parameter int ALE_SECOND = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ale_block_first,
    input  logic                           ale_block_second,
    output logic [$clog2(STATES + 1)-1:0]  state_num,
    output logic                           phase,
    output logic [STATES-1:0]              state_onehot,
    output logic                           cycle_end,
    output logic                           ale
);
    localparam int STATE_W = $clog2(STATES + 1);

    logic [STATE_W-1:0] cur_state;
    logic [STATE_W-1:0] nxt_state;
    phase_e             cur_phase;
    phase_e             nxt_phase;

    mcph_phase_ctr #(
        .STATES (STATES),
        .STATE_W(STATE_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_state(cur_state),
        .cur_phase(cur_phase),
        .nxt_state(nxt_state),
        .nxt_phase(nxt_phase)
    );

    mcph_strobe_dec #(
        .STATES    (STATES),
        .ALE_FIRST (ALE_FIRST),
        .ALE_SECOND(ALE_SECOND),
        .STATE_W   (STATE_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .nxt_state   (nxt_state),
        .nxt_phase   (nxt_phase),
        .block_first (ale_block_first),
        .block_second(ale_block_second),
        .onehot_q    (state_onehot),
        .cycle_end_q (cycle_end),
        .ale_q       (ale)
    );

    // Output mapping: expose counter registers directly.
    always_comb begin
        state_num = cur_state;
        phase     = cur_phase;
    end
endmodule

// File: rtl/mcph_gen_chk.sv
// Module: mcph_gen_chk
// Property checker bound to mcph_gen; observes ports only.
// Assumes default-style ALE placement given by the same parameters as the top.
module mcph_gen_chk #(
    parameter int STATES     = 6,
    parameter int ALE_FIRST  = 1,
    parameter int ALE_SECOND = 4,
    parameter int STATE_W    = $clog2(STATES + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ale_block_first,
    input logic               ale_block_second,
    input logic [STATE_W-1:0] state_num,
    input logic               phase,
    input logic [STATES-1:0]  state_onehot,
    input logic               cycle_end,
    input logic               ale
);
    localparam logic [STATE_W-1:0] LAST_ST = STATE_W'(STATES);
    localparam logic [STATE_W-1:0] A1      = STATE_W'(ALE_FIRST);
    localparam logic [STATE_W-1:0] A2      = STATE_W'(ALE_SECOND);

    p_phase_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase != $past(phase));

    p_state_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && state_num != LAST_ST) |=> state_num == $past(state_num) + 1'b1);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && state_num == LAST_ST) |=> (state_num == 1 && !phase));

    p_ale_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ((state_num == A1 && phase) || (state_num == A1 + 1'b1 && !phase) ||
                 (state_num == A2 && phase) || (state_num == A2 + 1'b1 && !phase)));

    p_ale_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && phase) |=> ale);

    p_ale_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_block_second && state_num == A2 && !phase) |=> !ale);

    p_cycle_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> (state_num == 1 && !phase && !cycle_end));

    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(state_onehot) == 1 &&
                          state_onehot[state_num - 1'b1]));

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (state_num == 1 && !phase && !ale && !cycle_end));
endmodule

bind mcph_gen mcph_gen_chk #(
    .STATES    (STATES),
    .ALE_FIRST (ALE_FIRST),
    .ALE_SECOND(ALE_SECOND)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ale_block_first (ale_block_first),
    .ale_block_second(ale_block_second),
    .state_num       (state_num),
    .phase           (phase),
    .state_onehot    (state_onehot),
    .cycle_end       (cycle_end),
    .ale             (ale)
);

// File: tb/mcph_gen_bench.sv
// Bench: directed scenarios, one task each, against an index model (0..11).
module mcph_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_a = 1'b0;
    logic       blk_b = 1'b0;
    logic [2:0] state_num;
    logic       phase;
    logic [5:0] state_onehot;
    logic       cycle_end;
    logic       ale;

    int checks = 0;
    int errors = 0;
    int idx = 0;          // model position in the 12-phase cycle
    logic lat_a = 1'b0;   // model's latched block decisions
    logic lat_b = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcph_gen u_mcph_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .ale_block_first (blk_a),
        .ale_block_second(blk_b),
        .state_num       (state_num),
        .phase           (phase),
        .state_onehot    (state_onehot),
        .cycle_end       (cycle_end),
        .ale             (ale)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (idx %0d)", req, act, exp, idx);
        end
    endtask

    // Advance one edge, update the model, sample 2 time units after the edge.
    task automatic step();
        logic ba;
        logic bb;
        ba = blk_a;
        bb = blk_b;
        @(posedge clk);
        if (!rst_n) begin
            idx = 0;
            lat_a = 1'b0;
            lat_b = 1'b0;
        end else begin
            idx = (idx + 1) % 12;
            if (idx == 1) lat_a = ba;
            if (idx == 7) lat_b = bb;
        end
        #2;
    endtask

    task automatic check_all();
        int exp_ale;
        exp_ale = 0;
        if (rst_n || idx != 0) begin
            if (idx == 1 || idx == 2) exp_ale = !lat_a;
            if (idx == 7 || idx == 8) exp_ale = !lat_b;
        end
        chk("R2 state", state_num, idx / 2 + 1);
        chk("R1 phase", phase, idx % 2);
        chk("R8 onehot", state_onehot, 1 << (idx / 2));
        chk("R7 cycle_end", cycle_end, idx == 11);
        chk("R3/R4 ale", ale, exp_ale);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        chk("R9 reset state", state_num, 1);
        chk("R9 reset phase", phase, 0);
        chk("R9 reset ale", ale, 0);
        chk("R9 reset cycle_end", cycle_end, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_walk();   // R1 R2 R3 R4 R7 R8 over three cycles
        for (int i = 0; i < 36; i++) begin
            step();
            check_all();
        end
    endtask

    task automatic t_block_first();   // R5
        int cnt;
        cnt = 0;
        while (idx != 0) step();
        blk_a = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step();
            if (idx == 1) blk_a = 1'b0;   // change inside the pulse window
            check_all();
            if (ale) cnt++;
        end
        chk("R5 pulses when first blocked", cnt, 2);
    endtask

    task automatic t_block_second();   // R6
        int cnt;
        cnt = 0;
        while (idx != 6) step();
        blk_b = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step();
            if (idx == 8) blk_b = 1'b0;
            check_all();
            if (ale) cnt++;
        end
        chk("R6 pulses when second blocked", cnt, 2);
    endtask

    task automatic t_mid_pulse_block();   // R5: late block does not cut pulse
        while (idx != 0) step();
        step();
        blk_a = 1'b1;   // raised while in S1P2, after the deciding edge
        step();
        check_all();
        chk("R5 pulse held in S2P1", ale, 1);
        blk_a = 1'b0;
    endtask

    task automatic t_sync_reset();   // R9
        while (idx != 4) step();
        #1;
        rst_n = 1'b0;
        #1;
        chk("R9 no effect before edge state", state_num, 3);
        chk("R9 no effect before edge phase", phase, 0);
        step();
        check_all();
        chk("R9 reset at edge state", state_num, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step();
            check_all();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_walk();
        t_block_first();
        t_block_second();
        t_mid_pulse_block();
        t_sync_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule